// File: doc/BRIEF.md
# E1 Sa-Bit Change and Sa6 Codeword Monitor

This block watches the spare national bits (Sa4 through Sa8) carried in the non-align frames of a received E1 stream. An upstream framer pulls the five bits out of each non-align frame and presents them with a strobe. The block keeps the most recent value of every Sa bit on a current-value output. It raises a latched change flag when any bit the host has selected differs from its value in the previous non-align frame.

The block also treats the four Sa6 bits of each 8-frame submultiframe as a 4-bit codeword. A codeword is accepted into the stored-code output only after the same value has arrived in three back-to-back submultiframes and differs from the code already held. Each acceptance sets a second latched flag. Both flags are masked individually onto a single interrupt line, and one read pulse clears them.

Top module: `sa_bit_monitor`

## Requirements
- R1: After reset, `sa_current`, `sa6_code`, `status` and `irq` are all zero.
- R2: `sa_current` takes the value of `sa_bits` at the clock edge where `nf_valid` is high and holds its value at every other edge. Bit 0 is Sa4 and bit 4 is Sa8.
- R3: At a strobed frame, `status[0]` sets if a bit selected in `sel_mask` differs from that bit in the previous strobed frame. The first strobed frame after reset is never compared.
- R4: A difference in a bit whose `sel_mask` bit is 0 does not set `status[0]`.
- R5: A high `status_rd` at an edge clears both status bits. A set event at the same edge wins over the clear.
- R6: `irq` is high exactly when some bit of `status` is 1 and its `irq_mask` bit is 1. Bit 0 is the Sa change flag and bit 1 is the Sa6 code flag.
- R7: A codeword collects the Sa6 bit (`sa_bits[2]`) of four strobed frames. It starts at the frame flagged by `smf_start`, and the first bit becomes the MSB. Strobed frames after the fourth are ignored until the next `smf_start`.
- R8: `sa6_code` loads a codeword when that value has completed in three consecutive submultiframes and differs from the stored code. `status[1]` sets at the same edge.
- R9: A codeword equal to the stored code causes neither an update nor a flag. A different completed codeword restarts the run of three.
- R10: An `smf_start` that arrives before four bits are collected discards the partial codeword and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nf_valid | input | 1 | Strobe: `sa_bits` holds one non-align frame |
| sa_bits | input | 5 | Sa4 (bit 0) to Sa8 (bit 4) of the frame |
| smf_start | input | 1 | With `nf_valid`: first non-align frame of a submultiframe |
| sel_mask | input | 5 | Selects the Sa bits watched for change |
| irq_mask | input | 2 | Enables each status bit onto `irq` |
| status_rd | input | 1 | Read pulse that clears the status bits |
| sa_current | output | 5 | Latest received Sa bits |
| sa6_code | output | 4 | Stored validated Sa6 codeword |
| status | output | 2 | Latched flags: bit 0 Sa change, bit 1 Sa6 code update |
| irq | output | 1 | Interrupt |

## Verification
`sa_current`, `sa6_code` and both status bits are registered. They change at the same rising edge that samples the strobe or the read pulse, so the bench drives inputs at a falling edge and compares against its model at the next falling edge. `irq` is combinational from the registered flags and the mask, so it is due in that same half cycle, and a change of mask alone is checked within the cycle it is applied. Codeword updates are due at the edge of the fourth Sa6 bit of the third matching submultiframe. The bench checks the cycle before that edge as well as the edge itself.

// File: rtl/sa_mon_pkg.sv
package sa_mon_pkg;
    localparam int SA_COUNT   = 5;  // Sa4..Sa8
    localparam int SA6_INDEX  = 2;  // position of Sa6 in the Sa vector
    localparam int CODE_BITS  = 4;  // Sa6 bits per submultiframe
    localparam int CONFIRM_N  = 3;  // matching submultiframes needed
    localparam int ST_BITS    = 2;
    localparam int ST_SA_CHG  = 0;
    localparam int ST_SA6_CHG = 1;
endpackage

// File: rtl/sa_change_det.sv
module sa_change_det #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         nf_valid,
    input  logic [N-1:0] sa_bits,
    input  logic [N-1:0] sel_mask,
    output logic [N-1:0] sa_cur,
    output logic         change_evt
);
    typedef struct packed {
        logic [N-1:0] cur;
        logic         have_prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [N-1:0] diff;

    always_comb begin
        st_d       = st_q;
        diff       = (sa_bits ^ st_q.cur) & sel_mask;
        change_evt = 1'b0;
        if (nf_valid) begin
            change_evt   = st_q.have_prev && (diff != '0);
            st_d.cur       = sa_bits;
            st_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sa_cur = st_q.cur;

    // R2: the held value moves only on a strobed frame
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_valid |=> $stable(sa_cur));
    // R3: no change event without a prior frame
    p_first_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_valid && !st_q.have_prev) |-> !change_evt);
endmodule

// File: rtl/sa6_code_filter.sv
module sa6_code_filter #(
    parameter int CW  = 4,
    parameter int CNF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nf_valid,
    input  logic          smf_start,
    input  logic          sa6_bit,
    output logic [CW-1:0] code,
    output logic          update_evt
);
    localparam int CNT_W = $clog2(CW + 1);
    localparam int RUN_W = $clog2(CNF + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CW);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(CNF);

    typedef struct packed {
        logic [CW-1:0]    acc;
        logic [CNT_W-1:0] cnt;   // CNT_FULL: word done, waiting for smf_start
        logic [CW-1:0]    cand;
        logic [RUN_W-1:0] run;
        logic [CW-1:0]    code;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic shifted;

    always_comb begin
        st_d       = st_q;
        shifted    = 1'b0;
        update_evt = 1'b0;
        if (nf_valid) begin
            if (smf_start) begin
                st_d.acc = {{(CW-1){1'b0}}, sa6_bit};
                st_d.cnt = CNT_W'(1);
                shifted  = 1'b1;
            end else if (st_q.cnt < CNT_FULL) begin
                st_d.acc = {st_q.acc[CW-2:0], sa6_bit};
                st_d.cnt = st_q.cnt + CNT_W'(1);
                shifted  = 1'b1;
            end
        end
        if (shifted && st_d.cnt == CNT_FULL) begin
            if (st_d.acc == st_q.cand) begin
                if (st_q.run < RUN_MAX) st_d.run = st_q.run + RUN_W'(1);
            end else begin
                st_d.cand = st_d.acc;
                st_d.run  = RUN_W'(1);
            end
            if (st_d.run == RUN_MAX && st_d.acc != st_q.code) begin
                st_d.code  = st_d.acc;
                update_evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{acc: '0, cnt: CNT_FULL, cand: '0, run: '0, code: '0};
        else        st_q <= st_d;
    end

    assign code = st_q.code;

    // R8: the stored code moves only on a strobed frame
    p_code_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_valid |=> $stable(code));
    // R9: a load always changes the stored value
    p_code_differs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |=> (code != $past(code)));
    // R7: the bit counter never runs past a full word
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);
endmodule

// File: rtl/sa_status_regs.sv
module sa_status_regs #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_evt,
    input  logic          rd,
    input  logic [NB-1:0] mask,
    output logic [NB-1:0] status,
    output logic          irq
);
    typedef struct packed {
        logic [NB-1:0] flags;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) st_d.flags = '0;
        st_d.flags = st_d.flags | set_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.flags;
    assign irq    = |(st_q.flags & mask);

    // R5: a set event is visible after its edge even under a read
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt != '0) |=> ((status & $past(set_evt)) == $past(set_evt)));
    // R5: a read with no event leaves nothing latched
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && set_evt == '0) |=> (status == '0));
endmodule

// File: rtl/sa_bit_monitor.sv
module sa_bit_monitor
    import sa_mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nf_valid,
    input  logic [SA_COUNT-1:0]  sa_bits,
    input  logic                 smf_start,
    input  logic [SA_COUNT-1:0]  sel_mask,
    input  logic [ST_BITS-1:0]   irq_mask,
    input  logic                 status_rd,
    output logic [SA_COUNT-1:0]  sa_current,
    output logic [CODE_BITS-1:0] sa6_code,
    output logic [ST_BITS-1:0]   status,
    output logic                 irq
);
    logic               sa_change_evt;
    logic               sa6_update_evt;
    logic [ST_BITS-1:0] set_vec;

    sa_change_det #(.N(SA_COUNT)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .nf_valid   (nf_valid),
        .sa_bits    (sa_bits),
        .sel_mask   (sel_mask),
        .sa_cur     (sa_current),
        .change_evt (sa_change_evt)
    );

    sa6_code_filter #(.CW(CODE_BITS), .CNF(CONFIRM_N)) u_sa6 (
        .clk        (clk),
        .rst_n      (rst_n),
        .nf_valid   (nf_valid),
        .smf_start  (smf_start),
        .sa6_bit    (sa_bits[SA6_INDEX]),
        .code       (sa6_code),
        .update_evt (sa6_update_evt)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[ST_SA_CHG]  = sa_change_evt;
        set_vec[ST_SA6_CHG] = sa6_update_evt;
    end

    sa_status_regs #(.NB(ST_BITS)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_vec),
        .rd      (status_rd),
        .mask    (irq_mask),
        .status  (status),
        .irq     (irq)
    );

    // R3: the change flag rises only after a strobed frame
    p_flag_needs_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_SA_CHG]) |-> $past(nf_valid));
    // R8: every new stored code is flagged
    p_code_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sa6_code != $past(sa6_code)) |-> status[ST_SA6_CHG]);
    // R6: no interrupt with everything masked
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);
endmodule

// File: tb/sa_bit_monitor_test.sv
module sa_bit_monitor_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nf_valid = 1'b0;
    logic [4:0] sa_bits = '0;
    logic       smf_start = 1'b0;
    logic [4:0] sel_mask = '0;
    logic [1:0] irq_mask = '0;
    logic       status_rd = 1'b0;
    logic [4:0] sa_current;
    logic [3:0] sa6_code;
    logic [1:0] status;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model
    logic [4:0] m_cur = '0;
    bit         m_have = 1'b0;
    logic [1:0] m_st = '0;
    logic [3:0] m_acc = '0, m_cand = '0, m_code = '0;
    int         m_cnt = 4;
    int         m_run = 0;

    sa_bit_monitor uut (
        .clk(clk), .rst_n(rst_n), .nf_valid(nf_valid), .sa_bits(sa_bits),
        .smf_start(smf_start), .sel_mask(sel_mask), .irq_mask(irq_mask),
        .status_rd(status_rd), .sa_current(sa_current), .sa6_code(sa6_code),
        .status(status), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void model_edge(bit v, logic [4:0] sa, bit smf, bit rd, logic [4:0] sel);
        bit shifted = 1'b0;
        if (rd) m_st = '0;
        if (v) begin
            if (m_have && (((sa ^ m_cur) & sel) != 0)) m_st[0] = 1'b1;
            m_have = 1'b1;
            m_cur  = sa;
            if (smf) begin
                m_acc = {3'b000, sa[2]}; m_cnt = 1; shifted = 1'b1;
            end else if (m_cnt < 4) begin
                m_acc = {m_acc[2:0], sa[2]}; m_cnt++; shifted = 1'b1;
            end
            if (shifted && m_cnt == 4) begin
                if (m_acc == m_cand) begin
                    if (m_run < 3) m_run++;
                end else begin
                    m_cand = m_acc; m_run = 1;
                end
                if (m_run == 3 && m_acc != m_code) begin
                    m_code = m_acc; m_st[1] = 1'b1;
                end
            end
        end
    endfunction

    function automatic logic exp_irq();
        return |(m_st & irq_mask);
    endfunction

    task automatic chk(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " R2 sa_current"}, int'(sa_current), int'(m_cur));
        chk({tag, " R3 status"},     int'(status),     int'(m_st));
        chk({tag, " R8 sa6_code"},   int'(sa6_code),   int'(m_code));
        chk({tag, " R6 irq"},        int'(irq),        int'(exp_irq()));
    endtask

    // at a falling edge: drive, take one rising edge, model it, return at falling edge
    task automatic step(bit v, logic [4:0] sa, bit smf, bit rd);
        nf_valid = v; sa_bits = sa; smf_start = smf; status_rd = rd;
        @(posedge clk);
        model_edge(v, sa, smf, rd, sel_mask);
        @(negedge clk);
        nf_valid = 1'b0; smf_start = 1'b0; status_rd = 1'b0;
    endtask

    // one submultiframe: four strobed frames carrying codeword cw on Sa6
    task automatic send_word(logic [3:0] cw);
        for (int i = 0; i < 4; i++) begin
            logic [4:0] sa = 5'b00000;
            sa[2] = cw[3-i];
            step(1'b1, sa, i == 0, 1'b0);
            if (i < 3) step(1'b0, 5'b0, 1'b0, 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sa_current", int'(sa_current), 0);
        chk("R1 sa6_code",   int'(sa6_code), 0);
        chk("R1 status",     int'(status), 0);
        chk("R1 irq",        int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 first frame is not compared
        sel_mask = 5'b11111;
        step(1'b1, 5'b10101, 1'b0, 1'b0);
        chk("R3 first frame no flag", int'(status[0]), 0);
        chk("R2 capture", int'(sa_current), 5'h15);
        step(1'b0, 5'b01010, 1'b0, 1'b0);
        chk("R2 hold without strobe", int'(sa_current), 5'h15);

        // R4 unselected change ignored
        sel_mask = 5'b00001;
        step(1'b1, 5'b01011, 1'b0, 1'b0);
        chk("R4 unselected change", int'(status[0]), 0);
        // R3 selected change (Sa4 toggles)
        step(1'b1, 5'b01010, 1'b0, 1'b0);
        chk("R3 selected change", int'(status[0]), 1);

        // R6 interrupt masking
        irq_mask = 2'b10; #1;
        chk("R6 masked irq", int'(irq), 0);
        irq_mask = 2'b01; #1;
        chk("R6 unmasked irq", int'(irq), 1);

        // R5 clear on read, then set wins over read
        step(1'b0, 5'b0, 1'b0, 1'b1);
        chk("R5 read clears", int'(status), 0);
        chk("R6 irq after clear", int'(irq), 0);
        step(1'b1, 5'b01011, 1'b0, 1'b1);
        chk("R5 set wins over read", int'(status[0]), 1);
        step(1'b0, 5'b0, 1'b0, 1'b1);

        // R7/R8 codeword 1011 three times
        sel_mask = 5'b00000;
        irq_mask = 2'b10;
        send_word(4'b1011);
        send_word(4'b1011);
        chk("R8 no update after two", int'(sa6_code), 0);
        send_word(4'b1011);
        chk("R7 R8 stored code MSB first", int'(sa6_code), 4'hB);
        chk("R8 code flag", int'(status[1]), 1);
        chk("R6 irq from code flag", int'(irq), 1);
        step(1'b0, 5'b0, 1'b0, 1'b1);
        // R9 same as stored: no new flag
        send_word(4'b1011);
        chk("R9 repeat stored no flag", int'(status[1]), 0);
        // R9 interrupted run
        send_word(4'b0110);
        send_word(4'b0110);
        send_word(4'b1100);
        send_word(4'b0110);
        send_word(4'b0110);
        chk("R9 interrupted run", int'(sa6_code), 4'hB);
        send_word(4'b0110);
        chk("R9 run of three after restart", int'(sa6_code), 4'h6);
        // R7 extra frames past the fourth ignored
        step(1'b1, 5'b00100, 1'b0, 1'b0);
        step(1'b1, 5'b00100, 1'b0, 1'b0);
        chk("R7 extra frames ignored", int'(sa6_code), 4'h6);
        // R10 partial word discarded
        step(1'b0, 5'b0, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 5'b00100, 1'b1, 1'b0);
            step(1'b1, 5'b00100, 1'b0, 1'b0);
            send_word(4'b0011);
        end
        chk("R10 partial discarded", int'(sa6_code), 4'h3);
        chk_all("directed end");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] sa;
            bit v, smf, rd;
            if ($urandom_range(0, 49) == 0) sel_mask = 5'($urandom);
            if ($urandom_range(0, 49) == 0) irq_mask = 2'($urandom);
            v   = ($urandom_range(0, 2) != 0);
            smf = ($urandom_range(0, 5) == 0);
            rd  = ($urandom_range(0, 9) == 0);
            sa  = 5'($urandom);
            sa[2] = (((n / 24) % 3) == 0) ? sa[2] : ((n % 3) == 0);
            step(v, sa, smf, rd);
            chk_all("random R2 R3 R4 R5 R6 R7 R8 R9 R10");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule